// File: doc/BRIEF.md
# Inbound Memory Window Decoder and Translator

This block is the target-side address decoder for one inbound memory window on a PCI-style bus. On each qualified address phase it tests whether the incoming address lies inside a window that software has programmed. When it does, the block claims the transaction and maps the bus address onto a 36-bit internal address. The window is defined by three values. A base value sets where the window sits. A mask, called the limit, marks which address bits select the window. The remaining bits are the offset inside the window, and that offset is merged with a translate value and a 4-bit upper translate value to form the internal address.

The lowest 8 KB of the window are set aside for a messaging unit. A claimed access to that region raises a messaging select in place of a translated address. In conventional (non PCI-X) mode, a burst whose order is not linear incrementing gets a disconnect request, so that only its first data phase completes. In PCI-X mode the block never requests this disconnect.

A small register port sets base, limit, translate value, upper translate value and upper base. All outputs are registered and appear one clock after the address strobe.

Top module: `inbound_window_xlate`

## Requirements
- R1: A claim is made only when the limit register is nonzero and (low address AND limit) equals the base register. With a limit of zero the block claims nothing.
- R2: For a dual-address cycle (dual_cycle=1), a claim also requires addr_hi to equal the upper base register. For a single-address cycle, addr_hi is not compared.
- R3: For a claimed access outside the messaging region, xlat_addr equals {upper_xlat, (addr_lo AND NOT limit) OR xlat}.
- R4: For a dual-address cycle, addr_hi does not enter the translated address. Only addr_lo is used.
- R5: When the in-window offset (addr_lo AND NOT limit) is below 8192, a claimed access sets msg_sel=1 and drives xlat_addr to zero. An offset of exactly 8192 is a normal translated access.
- R6: Only memory read (cmd 4'b0110) and memory write (cmd 4'b0111) can be claimed. Configuration read (4'b1010), configuration write (4'b1011) and every other code are never claimed.
- R7: In conventional mode (pcix_mode=0), a claimed access with burst_linear=0 raises disc_req. A claimed access with burst_linear=1 does not.
- R8: In PCI-X mode (pcix_mode=1), disc_req stays 0 whatever the burst order.
- R9: Register writes with reg_we=1 select the target through reg_sel: 0 base, 1 limit, 2 translate value, 3 upper translate value (reg_wdata[3:0]), 4 upper base. Codes 5 to 7 change nothing. All registers reset to zero.
- R10: Outputs are registered. They reflect the address phase that had addr_valid=1 in the previous clock, and a cycle without addr_valid produces no claim.
- R11: Whenever claim=0, xlat_addr is zero and both msg_sel and disc_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Address phase strobe |
| addr_lo | input | 32 | Low 32 address bits |
| addr_hi | input | 32 | Upper 32 address bits for dual-address cycles |
| dual_cycle | input | 1 | Address phase is a dual-address cycle |
| cmd | input | 4 | Bus command code |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional |
| burst_linear | input | 1 | 1 = linear incrementing burst order |
| claim | output | 1 | Transaction claimed |
| xlat_addr | output | 36 | Translated internal address |
| msg_sel | output | 1 | Messaging unit region hit |
| disc_req | output | 1 | Disconnect after first data phase |

## Verification
The hardest case to reach is the messaging boundary inside a dual-address claim, because it depends on three things at once. The upper base must match, the masked low address must match the base, and the offset must sit right next to 8192. The stimulus first programs every window register through the port. A vector table then places addresses at offsets 0x1FFC and 0x2000 and at the window's top word, and it includes an upper address that misses by one. Conventional and PCI-X modes are alternated with both burst orders, so that the disconnect rule is seen to depend only on the mode.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
  localparam int ADDR_W = 32;
  localparam int UX_W   = 4;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_LIMIT = 3'd1,
    SEL_XLAT  = 3'd2,
    SEL_UXLAT = 3'd3,
    SEL_UBASE = 3'd4
  } reg_sel_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] xlat;
    logic [UX_W-1:0]   uxlat;
    logic [ADDR_W-1:0] ubase;
  } win_cfg_t;
endpackage

// File: rtl/ibw_regs.sv
module ibw_regs
  import ibw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output win_cfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      case (sel)
        SEL_BASE:  cfg.base  <= wdata;
        SEL_LIMIT: cfg.limit <= wdata;
        SEL_XLAT:  cfg.xlat  <= wdata;
        SEL_UXLAT: cfg.uxlat <= wdata[UX_W-1:0];
        SEL_UBASE: cfg.ubase <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ibw_match.sv
module ibw_match
  import ibw_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic              dual_cycle,
  input  logic [3:0]        cmd,
  output logic              hit
);
  logic is_mem, lo_ok, hi_ok;

  always_comb begin
    is_mem = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    lo_ok  = (cfg.limit != '0) && ((addr_lo & cfg.limit) == cfg.base);
    hi_ok  = !dual_cycle || (addr_hi == cfg.ubase);
    hit    = is_mem && lo_ok && hi_ok;
  end
endmodule

// File: rtl/ibw_xlate.sv
module ibw_xlate
  import ibw_pkg::*;
#(
  parameter int MSG_BYTES = 8192
) (
  input  win_cfg_t               cfg,
  input  logic [ADDR_W-1:0]      addr_lo,
  output logic [ADDR_W+UX_W-1:0] xaddr,
  output logic                   in_msg
);
  localparam int MSG_LSB = $clog2(MSG_BYTES);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr_lo & ~cfg.limit;
    in_msg = (offset[ADDR_W-1:MSG_LSB] == '0);
    xaddr  = {cfg.uxlat, offset | cfg.xlat};
  end
endmodule

// File: rtl/inbound_window_xlate.sv
module inbound_window_xlate
  import ibw_pkg::*;
#(
  parameter int MSG_BYTES = 8192
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [2:0]             reg_sel,
  input  logic [ADDR_W-1:0]      reg_wdata,
  input  logic                   addr_valid,
  input  logic [ADDR_W-1:0]      addr_lo,
  input  logic [ADDR_W-1:0]      addr_hi,
  input  logic                   dual_cycle,
  input  logic [3:0]             cmd,
  input  logic                   pcix_mode,
  input  logic                   burst_linear,
  output logic                   claim,
  output logic [ADDR_W+UX_W-1:0] xlat_addr,
  output logic                   msg_sel,
  output logic                   disc_req
);
  localparam int XW = ADDR_W + UX_W;

  win_cfg_t        cfg;
  logic            hit, in_msg, take;
  logic [XW-1:0]   xaddr;

  ibw_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata), .cfg(cfg)
  );

  ibw_match u_match (
    .cfg(cfg), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .dual_cycle(dual_cycle), .cmd(cmd), .hit(hit)
  );

  ibw_xlate #(.MSG_BYTES(MSG_BYTES)) u_xlate (
    .cfg(cfg), .addr_lo(addr_lo), .xaddr(xaddr), .in_msg(in_msg)
  );

  assign take = addr_valid && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      claim     <= 1'b0;
      xlat_addr <= '0;
      msg_sel   <= 1'b0;
      disc_req  <= 1'b0;
    end else begin
      claim     <= take;
      msg_sel   <= take && in_msg;
      xlat_addr <= (take && !in_msg) ? xaddr : '0;
      disc_req  <= take && !pcix_mode && !burst_linear;
    end
  end

  // R10
  claim_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    claim |-> $past(addr_valid));
  // R6
  claim_mem_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    claim |-> ($past(cmd) == CMD_MEM_RD || $past(cmd) == CMD_MEM_WR));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !claim |-> (xlat_addr == '0 && !msg_sel && !disc_req));
  // R8
  pcix_no_disc_chk: assert property (@(posedge clk) disable iff (rst)
    disc_req |-> !$past(pcix_mode));
  // R5
  msg_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    msg_sel |-> (claim && xlat_addr == '0));
endmodule

// File: tb/inbound_window_xlate_bench.sv
module inbound_window_xlate_bench;
  typedef struct packed {
    logic        dual;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [3:0]  cmd;
    logic        pcix;
    logic        lin;
    logic        e_claim;
    logic        e_msg;
    logic        e_disc;
    logic [35:0] e_addr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0, 32'h8000_4000, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 36'hA_4560_4000}, // R1 R3
    '{1'b0, 32'h0, 32'h8000_1000, 4'b0111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 36'h0},          // R5
    '{1'b0, 32'h0, 32'h8010_0000, 4'b0110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R1 miss
    '{1'b0, 32'h0, 32'h8000_4000, 4'b1010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R6 cfg rd
    '{1'b0, 32'h0, 32'h8000_4000, 4'b1011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R6 cfg wr
    '{1'b1, 32'h1, 32'h800F_FFFC, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 36'hA_456F_FFFC}, // R2 R4
    '{1'b1, 32'h2, 32'h8000_4000, 4'b0110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R2 miss
    '{1'b0, 32'h0, 32'h8000_8000, 4'b0111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 36'hA_4560_8000}, // R7
    '{1'b0, 32'h0, 32'h8000_8000, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 36'hA_4560_8000}, // R8
    '{1'b0, 32'h0, 32'h8000_8000, 4'b0110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 36'hA_4560_8000}, // R7 linear
    '{1'b0, 32'h0, 32'h8000_2000, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 36'hA_4560_2000}, // R5 edge
    '{1'b1, 32'h1, 32'h8000_1FFC, 4'b0110, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 36'h0}           // R5 R7 dual
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic addr_valid = 1'b0, dual_cycle = 1'b0, pcix_mode = 1'b0, burst_linear = 1'b1;
  logic [31:0] addr_lo = '0, addr_hi = '0;
  logic [3:0] cmd = '0;
  logic claim, msg_sel, disc_req;
  logic [35:0] xlat_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  inbound_window_xlate u_inbound_window_xlate (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .addr_valid(addr_valid), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .dual_cycle(dual_cycle), .cmd(cmd), .pcix_mode(pcix_mode),
    .burst_linear(burst_linear), .claim(claim), .xlat_addr(xlat_addr),
    .msg_sel(msg_sel), .disc_req(disc_req)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input vec_t v, input string req);
    @(negedge clk);
    addr_valid = 1'b1; dual_cycle = v.dual; addr_hi = v.hi; addr_lo = v.lo;
    cmd = v.cmd; pcix_mode = v.pcix; burst_linear = v.lin;
    @(negedge clk);
    addr_valid = 1'b0;
    check({req, " claim"}, {35'd0, claim}, {35'd0, v.e_claim});
    check({req, " msg"},   {35'd0, msg_sel}, {35'd0, v.e_msg});
    check({req, " disc"},  {35'd0, disc_req}, {35'd0, v.e_disc});
    check({req, " addr"},  xlat_addr, v.e_addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 R11 reset state
    check("R9 R11 reset claim", {35'd0, claim}, 36'd0);
    check("R11 reset addr", xlat_addr, 36'd0);
    // R1 limit zero claims nothing after reset
    run('{1'b0, 32'h0, 32'h0000_0000, 4'b0110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0}, "R1 R9 unprogrammed");
    wr(3'd0, 32'h8000_0000);
    wr(3'd1, 32'hFFF0_0000);
    wr(3'd2, 32'h4560_0000);
    wr(3'd3, 32'h0000_000A);
    wr(3'd4, 32'h0000_0001);
    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("vec%0d", i));
    // R9 unused select codes change nothing
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_0000);
    wr(3'd7, 32'h1234_5678);
    run(VECS[0], "R9 unused sel");
    // R10 no strobe, no claim
    @(negedge clk);
    addr_lo = 32'h8000_4000; cmd = 4'b0110; dual_cycle = 1'b0;
    @(negedge clk);
    check("R10 no strobe", {35'd0, claim}, 36'd0);
    check("R11 no strobe addr", xlat_addr, 36'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule